// File: doc/BRIEF.md
# MSI Interrupt Request Controller

This block sits between application logic that wants to raise message-signalled interrupts and the transmit path that carries those messages upstream. It serves two physical functions. Each function has its own enable, vector-count setting, per-vector mask, base message data and per-vector pending record. A requester holds a request naming a function, a 5-bit vector number and a 3-bit traffic class. For each request the block makes one of three decisions: issue a message on the transmit handshake, record the vector as pending because it is masked, or reject the request.

The outgoing message data is the function's programmed data word. Its low bits are replaced by the vector number, and only as many low bits as the function's vector-count setting enables are replaced. Every request ends with a one-cycle acknowledge that carries a 2-bit outcome code. A side port lets software-managed logic set or clear a single pending bit. Both functions' pending records are visible at all times on one 64-bit output.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration and pending register is zero. `ack` and `tx_valid` are low, and `pending_all` is zero.
- R2: A request that is accepted for sending raises `tx_valid` one cycle after it is sampled. `tx_data` is the function's data word with its low `k` bits replaced by the low `k` bits of the vector, where `k` is the function's vector-count setting (capped at 5). `tx_tc` is the request's traffic class. `tx_valid`, `tx_data` and `tx_tc` hold steady until `tx_ready` is seen.
- R3: When the transmit handshake completes, `ack` rises one cycle later with status 2'b00. `ack` is always a single-cycle pulse.
- R4: A request for an enabled, in-range vector whose mask bit is set does not touch the transmit path. It sets that vector's pending bit and is acknowledged one cycle after it is sampled with status 2'b01.
- R5: A request to a function whose enable bit is clear is acknowledged one cycle after it is sampled with status 2'b10. It issues no message and changes no pending bit.
- R6: A vector number at or above 2^k for the function (with k as in R2) is invalid and is acknowledged with status 2'b10 in the same way. A setting of 6 or 7 behaves as 5, which allows all 32 vectors.
- R7: Status 2'b11 is never produced.
- R8: A pending-bit write (`pb_we`) writes `pb_wdata` into the bit at position `req_vec` of the pending register of function `req_fn`.
- R9: A pending-bit write while `req` is high, or while a request is still being handled, is ignored and leaves `pending_all` unchanged.
- R10: `pending_all[31:0]` is function 0's pending register and `pending_all[63:32]` is function 1's.
- R11: Configuration writes (`cfg_we`) load the register chosen by `cfg_sel` for function `cfg_fn`. The selector values are: 0 = enable (`cfg_wdata[0]`), 1 = vector-count setting (`cfg_wdata[2:0]`), 2 = mask (`cfg_wdata[31:0]`, bit n masks vector n), 3 = data word (`cfg_wdata[15:0]`).
- R12: The two functions are independent. Requests and settings for one function never change the outcome for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fn | input | 1 | Function targeted by the configuration write |
| cfg_sel | input | 2 | Register select: 0 enable, 1 vector count, 2 mask, 3 data |
| cfg_wdata | input | 32 | Configuration write value |
| req | input | 1 | Interrupt request level, held until `ack` |
| req_fn | input | 1 | Function of the request or pending-bit write |
| req_vec | input | 5 | Vector number; also the bit position for pending writes |
| req_tc | input | 3 | Traffic class for the message |
| pb_we | input | 1 | Pending-bit write strobe |
| pb_wdata | input | 1 | Value written to the pending bit |
| ack | output | 1 | One-cycle request acknowledge |
| ack_status | output | 2 | Outcome: 00 sent, 01 pending, 10 aborted |
| tx_valid | output | 1 | Message ready for the transmit path |
| tx_ready | input | 1 | Transmit path accepts the message |
| tx_data | output | 16 | Message data with the merged vector |
| tx_tc | output | 3 | Traffic class of the message |
| pending_all | output | 64 | Pending registers of both functions |

## Verification
A decision taken from the wrong state shows up within one or two cycles of the request. It appears either as the wrong status code on the acknowledge or as a message on the transmit port where none should be. The latency of the acknowledge also shows which path the controller took. A corrupted merge of the vector into the data word appears in `tx_data` as soon as `tx_valid` rises. A stray pending update is visible on `pending_all` on the cycle after the edge that caused it, so the bench compares that bus after every operation that may or may not modify it.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_ACK  = 2'd2
    } req_state_e;

    localparam logic [1:0] STS_SENT    = 2'b00;
    localparam logic [1:0] STS_PENDING = 2'b01;
    localparam logic [1:0] STS_ABORT   = 2'b10;

    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_MASK   = 2'd2;
    localparam logic [1:0] SEL_DATA   = 2'd3;

    localparam int COUNT_W = 3;

endpackage

// File: rtl/msi_func_regs.sv
module msi_func_regs
    import msi_irq_pkg::*;
#(
    parameter int VEC_W  = 5,
    parameter int DATA_W = 16,
    localparam int NVEC  = 1 << VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [NVEC-1:0]    cfg_wdata,
    input  logic               pend_set,
    input  logic [VEC_W-1:0]   bit_idx,
    input  logic               pb_we,
    input  logic               pb_val,
    output logic               fn_en,
    output logic [COUNT_W-1:0] fn_count,
    output logic [NVEC-1:0]    fn_mask,
    output logic [DATA_W-1:0]  fn_data,
    output logic [NVEC-1:0]    fn_pend
);

    typedef struct packed {
        logic               en;
        logic [COUNT_W-1:0] count;
        logic [NVEC-1:0]    mask;
        logic [DATA_W-1:0]  data;
        logic [NVEC-1:0]    pend;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_ENABLE: r_d.en    = cfg_wdata[0];
                SEL_COUNT:  r_d.count = cfg_wdata[COUNT_W-1:0];
                SEL_MASK:   r_d.mask  = cfg_wdata;
                default:    r_d.data  = cfg_wdata[DATA_W-1:0];
            endcase
        end
        if (pend_set) begin
            r_d.pend[bit_idx] = 1'b1;
        end else if (pb_we) begin
            r_d.pend[bit_idx] = pb_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fn_en    = r_q.en;
    assign fn_count = r_q.count;
    assign fn_mask  = r_q.mask;
    assign fn_data  = r_q.data;
    assign fn_pend  = r_q.pend;

    // Pending record moves only on a masked request or an accepted pending write
    p_pend_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_set && !pb_we) |=> $stable(fn_pend));

    // A pending write lands at the addressed bit
    p_pend_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_we && !pend_set) |=> (fn_pend[$past(bit_idx)] == $past(pb_val)));

    // A masked request leaves its bit set
    p_pend_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set |=> fn_pend[$past(bit_idx)]);

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_irq_pkg::*;
#(
    parameter int VEC_W  = 5,
    parameter int DATA_W = 16,
    parameter int TC_W   = 3,
    localparam int NVEC  = 1 << VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [VEC_W-1:0]   req_vec,
    input  logic [TC_W-1:0]    req_tc,
    input  logic               fn_en,
    input  logic [COUNT_W-1:0] fn_count,
    input  logic [NVEC-1:0]    fn_mask,
    input  logic [DATA_W-1:0]  fn_data,
    input  logic               tx_ready,
    output logic               idle,
    output logic               pend_set,
    output logic               ack,
    output logic [1:0]         ack_status,
    output logic               tx_valid,
    output logic [DATA_W-1:0]  tx_data,
    output logic [TC_W-1:0]    tx_tc
);

    typedef struct packed {
        req_state_e        st;
        logic              ack;
        logic [1:0]        sts;
        logic              txv;
        logic [DATA_W-1:0] txd;
        logic [TC_W-1:0]   tc;
    } fsm_t;

    fsm_t s_d, s_q;

    int unsigned       eff_bits;
    logic              vec_ok;
    logic [DATA_W-1:0] merged;

    // Number of low data bits taken from the vector, capped at the vector width
    always_comb begin
        if (int'(fn_count) > VEC_W) eff_bits = VEC_W;
        else                        eff_bits = int'(fn_count);
    end

    always_comb begin
        vec_ok = 1'b1;
        merged = fn_data;
        for (int i = 0; i < VEC_W; i++) begin
            if (i >= int'(eff_bits) && req_vec[i]) vec_ok = 1'b0;
            if (i <  int'(eff_bits) && i < DATA_W) merged[i] = req_vec[i];
        end
    end

    always_comb begin
        s_d      = s_q;
        pend_set = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.ack = 1'b0;
                if (req) begin
                    if (!fn_en || !vec_ok) begin
                        s_d.ack = 1'b1;
                        s_d.sts = STS_ABORT;
                        s_d.st  = ST_ACK;
                    end else if (fn_mask[req_vec]) begin
                        pend_set = 1'b1;
                        s_d.ack  = 1'b1;
                        s_d.sts  = STS_PENDING;
                        s_d.st   = ST_ACK;
                    end else begin
                        s_d.txv = 1'b1;
                        s_d.txd = merged;
                        s_d.tc  = req_tc;
                        s_d.st  = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    s_d.txv = 1'b0;
                    s_d.ack = 1'b1;
                    s_d.sts = STS_SENT;
                    s_d.st  = ST_ACK;
                end
            end
            default: begin
                s_d.ack = 1'b0;
                s_d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idle       = (s_q.st == ST_IDLE);
    assign ack        = s_q.ack;
    assign ack_status = s_q.ack ? s_q.sts : 2'b00;
    assign tx_valid   = s_q.txv;
    assign tx_data    = s_q.txd;
    assign tx_tc      = s_q.tc;

    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_no_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ack_status != 2'b11));

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_tc)));

    p_sent_after_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_status == STS_SENT) |-> $past(tx_valid && tx_ready));

    p_no_tx_on_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_status != STS_SENT) |-> !$past(tx_valid));

endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
    import msi_irq_pkg::*;
#(
    parameter int NFUNC  = 2,
    parameter int VEC_W  = 5,
    parameter int DATA_W = 16,
    parameter int TC_W   = 3,
    localparam int NVEC  = 1 << VEC_W,
    localparam int FN_W  = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [FN_W-1:0]       cfg_fn,
    input  logic [1:0]            cfg_sel,
    input  logic [NVEC-1:0]       cfg_wdata,
    input  logic                  req,
    input  logic [FN_W-1:0]       req_fn,
    input  logic [VEC_W-1:0]      req_vec,
    input  logic [TC_W-1:0]       req_tc,
    input  logic                  pb_we,
    input  logic                  pb_wdata,
    output logic                  ack,
    output logic [1:0]            ack_status,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [DATA_W-1:0]     tx_data,
    output logic [TC_W-1:0]       tx_tc,
    output logic [NFUNC*NVEC-1:0] pending_all
);

    logic               en_a    [NFUNC];
    logic [COUNT_W-1:0] count_a [NFUNC];
    logic [NVEC-1:0]    mask_a  [NFUNC];
    logic [DATA_W-1:0]  data_a  [NFUNC];
    logic [NVEC-1:0]    pend_a  [NFUNC];

    logic idle;
    logic pend_set;
    logic pb_ok;

    // A pending write is honoured only with no request in flight
    assign pb_ok = pb_we && !req && idle;

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
        logic cfg_hit;
        logic req_hit;
        assign cfg_hit = cfg_we && (cfg_fn == FN_W'(f));
        assign req_hit = (req_fn == FN_W'(f));

        msi_func_regs #(
            .VEC_W  (VEC_W),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_hit),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .pend_set  (pend_set && req_hit),
            .bit_idx   (req_vec),
            .pb_we     (pb_ok && req_hit),
            .pb_val    (pb_wdata),
            .fn_en     (en_a[f]),
            .fn_count  (count_a[f]),
            .fn_mask   (mask_a[f]),
            .fn_data   (data_a[f]),
            .fn_pend   (pend_a[f])
        );

        assign pending_all[f*NVEC +: NVEC] = pend_a[f];
    end

    msi_req_fsm #(
        .VEC_W  (VEC_W),
        .DATA_W (DATA_W),
        .TC_W   (TC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_vec    (req_vec),
        .req_tc     (req_tc),
        .fn_en      (en_a[req_fn]),
        .fn_count   (count_a[req_fn]),
        .fn_mask    (mask_a[req_fn]),
        .fn_data    (data_a[req_fn]),
        .tx_ready   (tx_ready),
        .idle       (idle),
        .pend_set   (pend_set),
        .ack        (ack),
        .ack_status (ack_status),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_tc      (tx_tc)
    );

    // A pending write during an outstanding request must not alter the pending bus
    p_pb_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_we && req && !pend_set) |=> $stable(pending_all));

endmodule

// File: tb/tb_msi_irq_ctrl.sv
module tb_msi_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [0:0]  cfg_fn;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        req;
    logic [0:0]  req_fn;
    logic [4:0]  req_vec;
    logic [2:0]  req_tc;
    logic        pb_we;
    logic        pb_wdata;
    logic        ack;
    logic [1:0]  ack_status;
    logic        tx_valid;
    logic        tx_ready;
    logic [15:0] tx_data;
    logic [2:0]  tx_tc;
    logic [63:0] pending_all;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    msi_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_fn(cfg_fn), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req(req), .req_fn(req_fn), .req_vec(req_vec), .req_tc(req_tc),
        .pb_we(pb_we), .pb_wdata(pb_wdata),
        .ack(ack), .ack_status(ack_status),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_tc(tx_tc),
        .pending_all(pending_all)
    );

    // fn[26] vec[25:21] tc[20:18] status[17:16] data[15:0]
    localparam logic [26:0] VEC_TBL [8] = '{
        {1'b0, 5'd5,  3'd3, 2'b00, 16'hA5F5},  // R2 R11 merge 3 bits
        {1'b0, 5'd0,  3'd7, 2'b00, 16'hA5F0},  // R2
        {1'b0, 5'd2,  3'd1, 2'b01, 16'h0000},  // R4 masked
        {1'b0, 5'd8,  3'd0, 2'b10, 16'h0000},  // R6 above count
        {1'b0, 5'd31, 3'd0, 2'b10, 16'h0000},  // R6
        {1'b1, 5'd0,  3'd4, 2'b00, 16'h1234},  // R12 fn1 one vector
        {1'b1, 5'd1,  3'd0, 2'b10, 16'h0000},  // R6 R12
        {1'b0, 5'd7,  3'd2, 2'b00, 16'hA5F7}   // R2
    };

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic f, input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_fn = f; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pend_write(input logic f, input logic [4:0] idx, input logic val);
        @(negedge clk);
        pb_we = 1'b1; req_fn = f; req_vec = idx; pb_wdata = val;
        @(negedge clk);
        pb_we = 1'b0;
    endtask

    task automatic do_req(input logic f, input logic [4:0] v, input logic [2:0] tc,
                          input int rdly, input bit with_pb,
                          output logic [1:0] st, output logic [15:0] d, output logic [2:0] t,
                          output int lat, output bit saw_tx, output bit unstable);
        int waited;
        bit done;
        waited = 0; done = 0; lat = 0; saw_tx = 0; unstable = 0;
        st = 2'b11; d = '0; t = '0;
        @(negedge clk);
        req = 1'b1; req_fn = f; req_vec = v; req_tc = tc;
        if (with_pb) begin pb_we = 1'b1; pb_wdata = 1'b1; end
        for (int k = 0; k < 30 && !done; k++) begin
            @(negedge clk);
            pb_we = 1'b0;
            lat++;
            if (ack) begin
                st = ack_status;
                done = 1;
                req = 1'b0;
                tx_ready = 1'b0;
            end else if (tx_valid) begin
                if (!saw_tx) begin
                    d = tx_data; t = tx_tc; saw_tx = 1;
                end else if (tx_data != d || tx_tc != t) begin
                    unstable = 1;
                end
                if (waited >= rdly) tx_ready = 1'b1;
                waited++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [26:0] e;
        logic [1:0]  st;
        logic [15:0] d;
        logic [2:0]  t;
        int          lat;
        bit          saw, uns;

        rst_n = 1'b0; cfg_we = 0; cfg_fn = 0; cfg_sel = 0; cfg_wdata = 0;
        req = 0; req_fn = 0; req_vec = 0; req_tc = 0; pb_we = 0; pb_wdata = 0; tx_ready = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ack && !tx_valid, "R1 ack/tx_valid", {ack, tx_valid}, 0);
        check(pending_all == 64'h0, "R1 pending", pending_all, 0);
        rst_n = 1'b1;

        // R5: fresh function has enable clear
        do_req(1'b0, 5'd0, 3'd0, 0, 0, st, d, t, lat, saw, uns);
        check(st == 2'b10, "R5 disabled status", st, 2'b10);
        check(lat == 1 && !saw, "R5 no tx latency", lat, 1);

        // R11 configuration
        cfg_write(1'b0, 2'd0, 32'h1);
        cfg_write(1'b0, 2'd1, 32'h3);
        cfg_write(1'b0, 2'd2, 32'h4);
        cfg_write(1'b0, 2'd3, 32'hA5F0);
        cfg_write(1'b1, 2'd0, 32'h1);
        cfg_write(1'b1, 2'd1, 32'h0);
        cfg_write(1'b1, 2'd3, 32'h1234);

        for (int i = 0; i < 8; i++) begin
            e = VEC_TBL[i];
            do_req(e[26], e[25:21], e[20:18], i % 3, 0, st, d, t, lat, saw, uns);
            check(st == e[17:16], "R3 R4 R6 R7 status", st, e[17:16]);
            if (e[17:16] == 2'b00) begin
                check(saw && d == e[15:0], "R2 tx_data", d, e[15:0]);
                check(t == e[20:18], "R2 tx_tc", t, e[20:18]);
                check(!uns, "R2 hold while stalled", uns, 0);
                check(lat == (i % 3) + 2, "R3 ack latency", lat, (i % 3) + 2);
            end else begin
                check(!saw, "R4 R5 no message", saw, 0);
                check(lat == 1, "R4 R6 ack latency", lat, 1);
            end
        end
        // R4 R10: masked vector 2 of fn0 marked pending
        check(pending_all == 64'h4, "R4 R10 pending after table", pending_all, 64'h4);

        // R8 R10: fn1 bit 17 set then cleared
        pend_write(1'b1, 5'd17, 1'b1);
        check(pending_all == (64'h4 | (64'h1 << 49)), "R8 R10 set fn1 bit", pending_all, 64'h4 | (64'h1 << 49));
        pend_write(1'b1, 5'd17, 1'b0);
        check(pending_all == 64'h4, "R8 clear fn1 bit", pending_all, 64'h4);
        pend_write(1'b0, 5'd2, 1'b0);
        check(pending_all == 64'h0, "R8 clear fn0 bit", pending_all, 64'h0);

        // R9: pending write during an outstanding request is dropped
        do_req(1'b0, 5'd8, 3'd0, 0, 1, st, d, t, lat, saw, uns);
        check(st == 2'b10, "R9 request status", st, 2'b10);
        check(pending_all == 64'h0, "R9 pending unchanged", pending_all, 64'h0);

        // R5: disable fn1; fn0 unaffected (R12)
        cfg_write(1'b1, 2'd0, 32'h0);
        do_req(1'b1, 5'd0, 3'd0, 0, 0, st, d, t, lat, saw, uns);
        check(st == 2'b10 && !saw, "R5 fn1 disabled", st, 2'b10);
        check(pending_all == 64'h0, "R5 pending untouched", pending_all, 64'h0);
        do_req(1'b0, 5'd1, 3'd5, 0, 0, st, d, t, lat, saw, uns);
        check(st == 2'b00 && d == 16'hA5F1, "R12 fn0 still sends", d, 16'hA5F1);

        // R6: count setting 7 acts as 5, vector 31 valid
        cfg_write(1'b1, 2'd0, 32'h1);
        cfg_write(1'b1, 2'd1, 32'h7);
        do_req(1'b1, 5'd31, 3'd6, 4, 0, st, d, t, lat, saw, uns);
        check(st == 2'b00, "R6 capped count status", st, 2'b00);
        check(d == 16'h123F && t == 3'd6, "R6 full merge", d, 16'h123F);
        check(!uns && lat == 6, "R2 R3 long stall", lat, 6);

        // R4 on fn1 with mask, high half of pending bus (R10)
        cfg_write(1'b1, 2'd2, 32'h8000_0000);
        do_req(1'b1, 5'd31, 3'd0, 0, 0, st, d, t, lat, saw, uns);
        check(st == 2'b01 && !saw, "R4 fn1 masked", st, 2'b01);
        check(pending_all == 64'h8000_0000_0000_0000, "R10 fn1 msb", pending_all, 64'h8000_0000_0000_0000);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(pending_all == 64'h0 && !ack, "R1 reset clears", pending_all, 0);
        do_req(1'b0, 5'd0, 3'd0, 0, 0, st, d, t, lat, saw, uns);
        check(st == 2'b10, "R1 enable cleared by reset", st, 2'b10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule